// File: doc/BRIEF.md
# Demand-Reloaded Context Register Cache

This block is the operand register file of a pipelined core that needs to change thread context, or enter and leave a call frame, in a single cycle. It keeps a small fast file that holds one context, and a larger backing store that holds every context. Each retired result is written to both at once. Because of that, no context ever has to be saved.

A switch strobe loads the new context number and clears every per-register presence flag in the same cycle. After the switch, the first read of each register finds its flag clear. The block then raises stall, reads the backing store (one-cycle synchronous latency), writes the value into the fast file and sets the flag. Registers that are never read in a context are never reloaded. The pipeline stalls while `stall` is high and keeps its read addresses and enables steady.

Top module: `ctx_regcache`

## Requirements
- R1: Reset clears every presence flag and selects context 0. A write made before any switch therefore lands in context 0, and any enabled read after reset stalls.
- R2: A write with `wb_en` high stores `wb_data` in the fast file and also in the backing store at {current context, `wb_idx`}. A later reload of that register in that context returns the written value.
- R3: A cycle with `ctx_switch` high clears all presence flags at its closing edge and makes `ctx_sel` the current context, whatever the block was doing.
- R4: An enabled read of an absent register holds `stall` high for exactly two cycles: the backing-store read, then the fill. In the third cycle the port shows the stored value and `stall` is low, unless the other port still misses.
- R5: When both ports miss, port A is refilled first and port B second, which gives four stall cycles. When both ports name the same absent register, one refill serves both, which gives two stall cycles.
- R6: A write sets the register's presence flag (except in a switch cycle), so a read of that register in the next cycle does not stall and returns the written value.
- R7: A switch that arrives during the fill cycle of a refill cancels the fill. The refilled register stays absent in the new context and is reloaded from the new context's slot.
- R8: A write to the register being refilled, made in the fill cycle, takes precedence over the reload. The fast file keeps the written value and the stale backing-store value is discarded.
- R9: A read port whose enable is low never causes a stall, whatever its address.
- R10: A read port whose register is present shows the fast-file value in the same cycle, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_sel | input | 3 | Context number taken on a switch |
| ctx_switch | input | 1 | One-cycle strobe: change context and clear presence flags |
| rda_en | input | 1 | Read port A enable |
| rda_idx | input | 5 | Read port A register index |
| rda_data | output | 32 | Read port A data |
| rdb_en | input | 1 | Read port B enable |
| rdb_idx | input | 5 | Read port B register index |
| rdb_data | output | 32 | Read port B data |
| wb_en | input | 1 | Write-back enable |
| wb_idx | input | 5 | Write-back register index |
| wb_data | input | 32 | Write-back data |
| stall | output | 1 | High while an enabled operand is absent or a refill is in flight |

## Verification
There are two collisions to provoke, and both use the fill cycle of a refill. In the first, a context switch strobe is driven in the fill cycle. The switch must win, so a later read of the same index in the new context must stall for two cycles again and return the new context's value. In the second, a write-back to the very register being refilled is driven in the fill cycle. The write must win, so the next read must be stall-free and return the written value. A later switch away and back must then reload that same value from the backing store.

// File: rtl/ctx_regcache_pkg.sv
package ctx_regcache_pkg;
    typedef enum logic [0:0] {
        FILL_IDLE = 1'b0,
        FILL_WAIT = 1'b1
    } fill_st_e;
endpackage

// File: rtl/crc_backing.sv
module crc_backing #(
    parameter int NCTX = 8,
    parameter int NREG = 32,
    parameter int DW   = 32
) (
    input  logic                              clk,
    input  logic                              we_i,
    input  logic [$clog2(NCTX*NREG)-1:0]      waddr_i,
    input  logic [DW-1:0]                     wdata_i,
    input  logic                              re_i,
    input  logic [$clog2(NCTX*NREG)-1:0]      raddr_i,
    output logic [DW-1:0]                     rdata_o
);
    localparam int DEPTH = NCTX * NREG;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rd_q;
    logic [DW-1:0] rd_d;

    always_comb begin
        rd_d = rd_q;
        if (re_i) rd_d = mem_q[raddr_i];
    end

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
        rd_q <= rd_d;
    end

    assign rdata_o = rd_q;
endmodule

// File: rtl/crc_fastfile.sv
module crc_fastfile #(
    parameter int NREG = 32,
    parameter int DW   = 32
) (
    input  logic                     clk,
    input  logic                     wa_en_i,
    input  logic [$clog2(NREG)-1:0]  wa_idx_i,
    input  logic [DW-1:0]            wa_data_i,
    input  logic                     wf_en_i,
    input  logic [$clog2(NREG)-1:0]  wf_idx_i,
    input  logic [DW-1:0]            wf_data_i,
    input  logic [$clog2(NREG)-1:0]  ra_idx_i,
    output logic [DW-1:0]            ra_data_o,
    input  logic [$clog2(NREG)-1:0]  rb_idx_i,
    output logic [DW-1:0]            rb_data_o
);
    logic [NREG-1:0][DW-1:0] mem_q;
    logic [NREG-1:0][DW-1:0] mem_d;

    always_comb begin
        mem_d = mem_q;
        if (wf_en_i) mem_d[wf_idx_i] = wf_data_i;
        if (wa_en_i) mem_d[wa_idx_i] = wa_data_i;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign ra_data_o = mem_q[ra_idx_i];
    assign rb_data_o = mem_q[rb_idx_i];

    // R8
    fill_wb_collide_chk: assert property (@(posedge clk)
        !(wa_en_i && wf_en_i && (wa_idx_i == wf_idx_i)));
endmodule

// File: rtl/crc_valid.sv
module crc_valid #(
    parameter int NREG = 32,
    parameter int NRD  = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                clr_i,
    input  logic                                set_a_i,
    input  logic [$clog2(NREG)-1:0]             set_a_idx_i,
    input  logic                                set_b_i,
    input  logic [$clog2(NREG)-1:0]             set_b_idx_i,
    input  logic [NRD-1:0][$clog2(NREG)-1:0]    rd_idx_i,
    output logic [NRD-1:0]                      rd_v_o
);
    logic [NREG-1:0] vec_q;
    logic [NREG-1:0] vec_d;

    always_comb begin
        vec_d = vec_q;
        if (clr_i) begin
            vec_d = '0;
        end else begin
            if (set_a_i) vec_d[set_a_idx_i] = 1'b1;
            if (set_b_i) vec_d[set_b_idx_i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vec_q <= '0;
        else        vec_q <= vec_d;
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rdmux
        assign rd_v_o[g] = vec_q[rd_idx_i[g]];
    end

    // R3
    flash_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (vec_q == '0));

    // R6
    wb_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_a_i && !clr_i) |=> vec_q[$past(set_a_idx_i)]);
endmodule

// File: rtl/ctx_regcache.sv
module ctx_regcache
    import ctx_regcache_pkg::*;
#(
    parameter int NCTX = 8,
    parameter int NREG = 32,
    parameter int DW   = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [$clog2(NCTX)-1:0]   ctx_sel,
    input  logic                      ctx_switch,
    input  logic                      rda_en,
    input  logic [$clog2(NREG)-1:0]   rda_idx,
    output logic [DW-1:0]             rda_data,
    input  logic                      rdb_en,
    input  logic [$clog2(NREG)-1:0]   rdb_idx,
    output logic [DW-1:0]             rdb_data,
    input  logic                      wb_en,
    input  logic [$clog2(NREG)-1:0]   wb_idx,
    input  logic [DW-1:0]             wb_data,
    output logic                      stall
);
    localparam int RW = $clog2(NREG);
    localparam int CW = $clog2(NCTX);
    localparam int BW = CW + RW;

    typedef struct packed {
        fill_st_e         st;
        logic [RW-1:0]    tgt;
        logic [CW-1:0]    ctx;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic           bs_re;
    logic [BW-1:0]  bs_raddr;
    logic [DW-1:0]  bs_rdata;
    logic           fill_we;
    logic           flags_clr;
    logic [2:0]     vflag;
    logic           miss_a, miss_b;
    logic           wb_hits_tgt;

    assign miss_a      = rda_en && !vflag[0];
    assign miss_b      = rdb_en && !vflag[1];
    assign wb_hits_tgt = wb_en && (wb_idx == ctl_q.tgt);

    always_comb begin
        ctl_d     = ctl_q;
        bs_re     = 1'b0;
        bs_raddr  = '0;
        fill_we   = 1'b0;
        flags_clr = 1'b0;
        unique case (ctl_q.st)
            FILL_IDLE: begin
                if (ctx_switch) begin
                    flags_clr = 1'b1;
                    ctl_d.ctx = ctx_sel;
                end else if (miss_a) begin
                    bs_re     = 1'b1;
                    bs_raddr  = {ctl_q.ctx, rda_idx};
                    ctl_d.st  = FILL_WAIT;
                    ctl_d.tgt = rda_idx;
                end else if (miss_b) begin
                    bs_re     = 1'b1;
                    bs_raddr  = {ctl_q.ctx, rdb_idx};
                    ctl_d.st  = FILL_WAIT;
                    ctl_d.tgt = rdb_idx;
                end
            end
            FILL_WAIT: begin
                ctl_d.st = FILL_IDLE;
                if (ctx_switch) begin
                    flags_clr = 1'b1;
                    ctl_d.ctx = ctx_sel;
                end else if (!vflag[2] && !wb_hits_tgt) begin
                    fill_we = 1'b1;
                end
            end
            default: ctl_d.st = FILL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st  <= FILL_IDLE;
            ctl_q.tgt <= '0;
            ctl_q.ctx <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign stall = (ctl_q.st == FILL_WAIT) || miss_a || miss_b;

    crc_valid #(.NREG(NREG), .NRD(3)) u_valid (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (flags_clr),
        .set_a_i     (wb_en),
        .set_a_idx_i (wb_idx),
        .set_b_i     (fill_we),
        .set_b_idx_i (ctl_q.tgt),
        .rd_idx_i    ({ctl_q.tgt, rdb_idx, rda_idx}),
        .rd_v_o      (vflag)
    );

    crc_fastfile #(.NREG(NREG), .DW(DW)) u_fast (
        .clk       (clk),
        .wa_en_i   (wb_en),
        .wa_idx_i  (wb_idx),
        .wa_data_i (wb_data),
        .wf_en_i   (fill_we),
        .wf_idx_i  (ctl_q.tgt),
        .wf_data_i (bs_rdata),
        .ra_idx_i  (rda_idx),
        .ra_data_o (rda_data),
        .rb_idx_i  (rdb_idx),
        .rb_data_o (rdb_data)
    );

    crc_backing #(.NCTX(NCTX), .NREG(NREG), .DW(DW)) u_store (
        .clk     (clk),
        .we_i    (wb_en),
        .waddr_i ({ctl_q.ctx, wb_idx}),
        .wdata_i (wb_data),
        .re_i    (bs_re),
        .raddr_i (bs_raddr),
        .rdata_o (bs_rdata)
    );

    // R4
    one_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == FILL_WAIT) |=> (ctl_q.st == FILL_IDLE));

    // R4
    wait_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == FILL_IDLE && !ctx_switch && rda_en && stall) |=> stall);

    // R5
    port_a_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == FILL_IDLE && !ctx_switch && miss_a) |=> (ctl_q.tgt == $past(rda_idx)));

    // R3
    ctx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_switch |=> (ctl_q.ctx == $past(ctx_sel)));

    // R7
    abort_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == FILL_WAIT && ctx_switch) |-> !fill_we);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == FILL_IDLE && !rda_en && !rdb_en) |-> !stall);
endmodule

// File: tb/sim_ctx_regcache.sv
module sim_ctx_regcache;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  ctx_sel;
    logic        ctx_switch;
    logic        rda_en, rdb_en, wb_en;
    logic [4:0]  rda_idx, rdb_idx, wb_idx;
    logic [31:0] rda_data, rdb_data, wb_data;
    logic        stall;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [31:0] ref_q [8][32];

    always #(CLK_PERIOD/2) clk = ~clk;

    ctx_regcache u0 (
        .clk(clk), .rst_n(rst_n), .ctx_sel(ctx_sel), .ctx_switch(ctx_switch),
        .rda_en(rda_en), .rda_idx(rda_idx), .rda_data(rda_data),
        .rdb_en(rdb_en), .rdb_idx(rdb_idx), .rdb_data(rdb_data),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .stall(stall)
    );

    // table entries: {context[12:10], port A index[9:5], port B index[4:0]}
    localparam logic [12:0] VEC [8] = '{
        {3'd3, 5'd1,  5'd2 },
        {3'd5, 5'd31, 5'd0 },
        {3'd0, 5'd7,  5'd7 },
        {3'd7, 5'd12, 5'd30},
        {3'd1, 5'd4,  5'd4 },
        {3'd6, 5'd16, 5'd17},
        {3'd2, 5'd9,  5'd3 },
        {3'd4, 5'd20, 5'd21}
    };

    function automatic logic [31:0] pat(int c, int r, int gen);
        pat = {8'(8'hA5 ^ gen), 8'(c), 8'(r), 8'(c * r + 7)};
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_switch(int c);
        @(negedge clk);
        ctx_switch = 1'b1; ctx_sel = 3'(c);
        @(negedge clk);
        ctx_switch = 1'b0;
    endtask

    task automatic do_write(int c, int r, logic [31:0] v);
        @(negedge clk);
        wb_en = 1'b1; wb_idx = 5'(r); wb_data = v;
        ref_q[c][r] = v;
        @(negedge clk);
        wb_en = 1'b0;
    endtask

    task automatic read_pair(int c, int a, int b, bit ea, bit eb, int exp_n, string tag);
        int n;
        @(negedge clk);
        rda_idx = 5'(a); rdb_idx = 5'(b); rda_en = ea; rdb_en = eb;
        #1;
        n = 0;
        while (stall && n < 20) begin
            n++;
            @(negedge clk);
            #1;
        end
        chk(n == exp_n, {tag, " stall cycles"}, 32'(n), 32'(exp_n));
        if (ea) chk(rda_data === ref_q[c][a], {tag, " port A data"}, rda_data, ref_q[c][a]);
        if (eb) chk(rdb_data === ref_q[c][b], {tag, " port B data"}, rdb_data, ref_q[c][b]);
        rda_en = 1'b0; rdb_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ctx_sel = '0; ctx_switch = 1'b0;
        rda_en = 1'b0; rdb_en = 1'b0; wb_en = 1'b0;
        rda_idx = '0; rdb_idx = '0; wb_idx = '0; wb_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, no flag present; R9: disabled ports quiet
        @(negedge clk); #1;
        chk(stall == 1'b0, "R9 reset idle no stall", 32'(stall), 32'd0);
        rda_idx = 5'd3; rda_en = 1'b1; #1;
        chk(stall == 1'b1, "R1 read after reset stalls", 32'(stall), 32'd1);
        rda_en = 1'b0;
        repeat (3) @(negedge clk);

        // R1: reset context is 0; R2: write-through reload
        do_write(0, 2, 32'h0BAD_F00D);
        do_switch(1);
        do_switch(0);
        read_pair(0, 2, 2, 1, 0, 2, "R1 reset context");

        // fill every context
        for (int c = 0; c < 8; c++) begin
            do_switch(c);
            for (int r = 0; r < 32; r++) do_write(c, r, pat(c, r, 0));
        end

        // table walk: interleaved contexts, double miss then hit
        for (int i = 0; i < 8; i++) begin
            int c, a, b;
            c = int'(VEC[i][12:10]); a = int'(VEC[i][9:5]); b = int'(VEC[i][4:0]);
            do_switch(c);
            read_pair(c, a, b, 1, 1, (a == b) ? 2 : 4, "R5 miss pair");
            read_pair(c, a, b, 1, 1, 0, "R10 hit pair");
        end

        // R4: single miss costs two cycles
        do_switch(6);
        read_pair(6, 11, 11, 1, 0, 2, "R4 single miss");

        // R9: disabled port B on absent register
        read_pair(6, 11, 25, 1, 0, 0, "R9 disabled port");

        // R6: write then read same context, no stall
        do_switch(3);
        do_write(3, 7, pat(3, 7, 1));
        read_pair(3, 7, 7, 1, 1, 0, "R6 write sets flag");
        // R2: write went to backing store
        do_switch(1);
        do_switch(3);
        read_pair(3, 7, 7, 1, 0, 2, "R2 write-through");

        // R7: switch during fill cycle aborts the refill
        do_switch(2);
        @(negedge clk);
        rda_idx = 5'd4; rda_en = 1'b1; rdb_en = 1'b0;
        @(negedge clk);
        ctx_switch = 1'b1; ctx_sel = 3'd5;
        @(negedge clk);
        ctx_switch = 1'b0; rda_en = 1'b0;
        read_pair(5, 4, 4, 1, 0, 2, "R7 aborted refill");

        // R8: write to refill target in fill cycle wins
        @(negedge clk);
        rda_idx = 5'd9; rda_en = 1'b1; rdb_en = 1'b0;
        @(negedge clk);
        wb_en = 1'b1; wb_idx = 5'd9; wb_data = pat(5, 9, 2);
        ref_q[5][9] = pat(5, 9, 2);
        @(negedge clk);
        wb_en = 1'b0; #1;
        chk(stall == 1'b0, "R8 no stall after wb", 32'(stall), 32'd0);
        chk(rda_data === ref_q[5][9], "R8 written value kept", rda_data, ref_q[5][9]);
        rda_en = 1'b0;
        do_switch(6);
        do_switch(5);
        read_pair(5, 9, 9, 1, 0, 2, "R8 R2 reload of written value");

        // R3: switch clears every flag, including earlier hits
        read_pair(5, 9, 9, 1, 0, 0, "R10 present again");
        do_switch(5);
        read_pair(5, 9, 4, 1, 1, 4, "R3 flags cleared");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule